// File: doc/BRIEF.md
# Pipeline Exception Commit Controller

This block holds back every fault of an in-order five-stage pipeline until the faulting instruction reaches the memory stage, which is the commit point. A fault seen at fetch, decode or execute is recorded in a small side band (a valid bit, a pending flag and a 4-bit cause code) that moves along with the instruction. If an older stage has already flagged a fault, a fault found in a later stage leaves that record as it is. At the commit point the controller chooses one of three outcomes for the instruction in the memory stage: it commits, it takes an exception, or it is displaced by an external interrupt.

When an exception or interrupt is taken, the controller does several things in the same cycle. It raises a kill on every stage, stops the memory-stage instruction from writing state, drops the instruction being fetched and steers fetch to a fixed handler address. On the next clock edge it latches the cause code and the PC of the excepting instruction, and it clears the interrupt-enable bit. The external interrupt request is asynchronous, so it passes through a parameterised synchronizer first, and it is honoured only while interrupt-enable is set. A return-from-exception instruction that commits steers fetch back to the saved PC and sets interrupt-enable again.

Top module: `exc_commit_ctrl`

## Requirements
- R1: After reset, exc_cause is 0, exc_epc is 0, irq_en is 1, and redirect, kill and commit_ok are all 0.
- R2: A fault flag enters with its instruction and acts only when that instruction is valid in the memory stage, which is three clock edges after fetch. A valid memory-stage instruction with no fault and no interrupt drives commit_ok high.
- R3: When one instruction reports faults in several stages, the earliest stage wins. The order is fetch, then decode, then execute, then memory.
- R4: The cause codes are 4'h1 for a fetch address fault, 4'h2 for an illegal opcode, 4'h3 for arithmetic overflow, 4'h4 for a data address fault and 4'hA for an external interrupt.
- R5: irq_req passes through SYNC_STAGES flip-flops. It is taken when it is synchronized high, irq_en is 1 and the memory stage holds a valid instruction. It then overrides any fault of that instruction.
- R6: On a taken exception or interrupt, exc_cause and exc_epc load the cause code and the memory-stage PC on the next clock edge.
- R7: On a taken exception or interrupt, redirect and all bits of kill go high in the same cycle and redirect_pc equals HANDLER_PC. The memory-stage instruction does not assert commit_ok, and the instruction fetched in that cycle is dropped.
- R8: An instruction killed in any stage never asserts commit_ok and never causes an exception later, even when its fault inputs are driven.
- R9: Taking an exception or interrupt clears irq_en on the next edge. While irq_en is 0, irq_req has no effect.
- R10: A valid memory-stage instruction with m_eret set and no fault or interrupt commits and redirects fetch to exc_epc, kills the younger stages and sets irq_en on the next edge. A fault or interrupt on the same instruction takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetch stage holds an instruction |
| f_pc | input | PC_W | PC of the fetched instruction |
| f_fault | input | 1 | Instruction address fault at fetch |
| d_illegal | input | 1 | Illegal opcode for the decode-stage instruction |
| e_ovf | input | 1 | Arithmetic overflow for the execute-stage instruction |
| m_daf | input | 1 | Data address fault for the memory-stage instruction |
| m_eret | input | 1 | Memory-stage instruction is a return from exception |
| irq_req | input | 1 | Asynchronous external interrupt request (level) |
| commit_ok | output | 1 | Memory-stage instruction may write registers and memory |
| redirect | output | 1 | Fetch must load redirect_pc |
| redirect_pc | output | PC_W | Handler address or saved PC |
| kill | output | 4 | One kill per stage (fetch, decode, execute, memory) |
| exc_cause | output | 4 | Cause register |
| exc_epc | output | PC_W | Exception PC register |
| irq_en | output | 1 | Interrupt-enable bit |

## Verification
redirect, kill, redirect_pc and commit_ok are combinational at the commit point. They are due in the cycle that follows the third rising edge after the instruction's fetch cycle, so the bench reads them at the falling edge of that cycle. exc_cause, exc_epc and irq_en are due one rising edge later, so the bench reads them just after that edge. An interrupt request counts only SYNC_STAGES edges after it is driven: the bench keeps its own history of the request level and uses it to decide when the request first competes at the commit point. Expected values come from a bench-side record of each instruction's planned faults as it moves through the stages. The bench drives the fault inputs of killed instructions on purpose, to show that they have no effect.

// File: rtl/exc_cmt_pkg.sv
package exc_cmt_pkg;

   localparam int CAUSE_W    = 4;
   localparam int NUM_STAGES = 4;   // fetch, decode, execute, memory

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE    = 4'h0,
      CAUSE_FETCH   = 4'h1,
      CAUSE_ILLEGAL = 4'h2,
      CAUSE_OVF     = 4'h3,
      CAUSE_DADDR   = 4'h4,
      CAUSE_IRQ     = 4'hA
   } cause_e;

   // side band carried with each instruction
   typedef struct packed {
      logic   vld;
      logic   exc;
      cause_e code;
   } tag_t;

   // code reported by the fault source local to stage position idx
   function automatic cause_e stage_cause(input int idx);
      case (idx)
         0:       return CAUSE_FETCH;
         1:       return CAUSE_ILLEGAL;
         2:       return CAUSE_OVF;
         default: return CAUSE_DADDR;
      endcase
   endfunction

endpackage

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else if (STAGES == 1) ff_q <= async_in;
            else ff_q <= {ff_q[STAGES-2:0], async_in};
         end
         assign sync_out = ff_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
   import exc_cmt_pkg::*;
#(
   parameter int     PC_W       = 32,
   parameter cause_e LOCAL_CODE = CAUSE_FETCH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  tag_t            in_tag,
   input  logic [PC_W-1:0] in_pc,
   input  logic            local_fault,
   output tag_t            q_tag,
   output logic [PC_W-1:0] q_pc
);

   tag_t merged;

   // an older fault is never replaced by a younger one
   always_comb begin
      merged.vld  = in_tag.vld;
      merged.exc  = in_tag.vld & (in_tag.exc | local_fault);
      if (in_tag.exc)       merged.code = in_tag.code;
      else if (local_fault) merged.code = LOCAL_CODE;
      else                  merged.code = CAUSE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_tag <= '{vld: 1'b0, exc: 1'b0, code: CAUSE_NONE};
         q_pc  <= '0;
      end else if (flush) begin
         q_tag <= '{vld: 1'b0, exc: 1'b0, code: CAUSE_NONE};
      end else begin
         q_tag <= merged;
         q_pc  <= in_pc;
      end
   end

   p_flush_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !q_tag.vld && !q_tag.exc)
      else $error("flushed stage still valid");

   p_older_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && in_tag.vld && in_tag.exc) |=> (q_tag.exc && q_tag.code == $past(in_tag.code)))
      else $error("older fault code overwritten");

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
   import exc_cmt_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  tag_t            m_tag,
   input  logic [PC_W-1:0] m_pc,
   input  logic            m_daf,
   input  logic            m_eret,
   input  logic            irq_s,
   output logic            commit_ok,
   output logic            redirect,
   output logic [PC_W-1:0] redirect_pc,
   output cause_e          cause_q,
   output logic [PC_W-1:0] epc_q,
   output logic            ie_q
);

   logic   fault, irq_take, taken, eret_go;
   cause_e fault_code, next_cause;

   always_comb begin
      fault      = m_tag.vld & (m_tag.exc | m_daf);
      fault_code = m_tag.exc ? m_tag.code : CAUSE_DADDR;
      irq_take   = irq_s & ie_q & m_tag.vld;
      taken      = irq_take | fault;
      next_cause = irq_take ? CAUSE_IRQ : fault_code;
      eret_go    = m_tag.vld & m_eret & ~taken;
      commit_ok  = m_tag.vld & ~taken;
      redirect   = taken | eret_go;
      redirect_pc = taken ? HANDLER_PC : epc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= CAUSE_NONE;
         epc_q   <= '0;
         ie_q    <= 1'b1;
      end else if (taken) begin
         cause_q <= next_cause;
         epc_q   <= m_pc;
         ie_q    <= 1'b0;
      end else if (eret_go) begin
         ie_q    <= 1'b1;
      end
   end

   p_taken_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> (redirect && !commit_ok))
      else $error("taken exception still commits");

   p_epc_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> epc_q == $past(m_pc))
      else $error("EPC not loaded");

   p_ie_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> !ie_q)
      else $error("interrupt enable not cleared");

   p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q && !fault) |-> !taken)
      else $error("masked interrupt taken");

   p_irq_over_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> cause_q == CAUSE_IRQ)
      else $error("interrupt did not win");

   p_eret_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eret_go |=> ie_q)
      else $error("return did not re-enable interrupts");

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
   import exc_cmt_pkg::*;
#(
   parameter int              PC_W        = 32,
   parameter logic [PC_W-1:0] HANDLER_PC  = 'h180,
   parameter int              SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  f_valid,
   input  logic [PC_W-1:0]       f_pc,
   input  logic                  f_fault,
   input  logic                  d_illegal,
   input  logic                  e_ovf,
   input  logic                  m_daf,
   input  logic                  m_eret,
   input  logic                  irq_req,
   output logic                  commit_ok,
   output logic                  redirect,
   output logic [PC_W-1:0]       redirect_pc,
   output logic [NUM_STAGES-1:0] kill,
   output logic [CAUSE_W-1:0]    exc_cause,
   output logic [PC_W-1:0]       exc_epc,
   output logic                  irq_en
);

   localparam int NUM_REGS = NUM_STAGES - 1;

   if (PC_W < 8 || PC_W > 64) begin : g_bad_pcw
      $error("PC_W must lie in 8..64");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must not exceed 4");
   end
   if (HANDLER_PC[1:0] != 2'b00) begin : g_bad_handler
      $error("HANDLER_PC must be word aligned");
   end

   tag_t            st_tag [NUM_STAGES];
   logic [PC_W-1:0] st_pc  [NUM_STAGES];
   logic [NUM_REGS-1:0] loc_fault;
   logic            irq_s;
   logic            flush;
   cause_e          cause_q;

   assign st_tag[0]  = '{vld: f_valid, exc: 1'b0, code: CAUSE_NONE};
   assign st_pc[0]   = f_pc;
   assign loc_fault  = {e_ovf, d_illegal, f_fault};

   exc_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_req),
      .sync_out (irq_s)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_stage
      exc_stage_reg #(
         .PC_W       (PC_W),
         .LOCAL_CODE (stage_cause(i))
      ) u_reg (
         .clk         (clk),
         .rst_n       (rst_n),
         .flush       (flush),
         .in_tag      (st_tag[i]),
         .in_pc       (st_pc[i]),
         .local_fault (loc_fault[i]),
         .q_tag       (st_tag[i+1]),
         .q_pc        (st_pc[i+1])
      );
   end

   exc_commit_unit #(
      .PC_W       (PC_W),
      .HANDLER_PC (HANDLER_PC)
   ) u_commit (
      .clk         (clk),
      .rst_n       (rst_n),
      .m_tag       (st_tag[NUM_STAGES-1]),
      .m_pc        (st_pc[NUM_STAGES-1]),
      .m_daf       (m_daf),
      .m_eret      (m_eret),
      .irq_s       (irq_s),
      .commit_ok   (commit_ok),
      .redirect    (redirect),
      .redirect_pc (redirect_pc),
      .cause_q     (cause_q),
      .epc_q       (exc_epc),
      .ie_q        (irq_en)
   );

   assign flush     = redirect;
   assign kill      = {NUM_STAGES{redirect}};
   assign exc_cause = cause_q;

   p_kill_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (kill == {NUM_STAGES{1'b1}}))
      else $error("not every stage killed");

endmodule

// File: tb/tb_exc_commit_ctrl.sv
module tb_exc_commit_ctrl;

   localparam int          PW   = 32;
   localparam logic [31:0] HPC  = 32'h0000_0180;
   localparam int          SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic f_valid = 0, f_fault = 0, d_illegal = 0, e_ovf = 0, m_daf = 0, m_eret = 0, irq_req = 0;
   logic [PW-1:0] f_pc = '0;
   logic commit_ok, redirect, irq_en;
   logic [PW-1:0] redirect_pc, exc_epc;
   logic [3:0] kill, exc_cause;

   always #2 clk = ~clk;   // 250 MHz

   exc_commit_ctrl #(.PC_W(PW), .HANDLER_PC(HPC), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc), .f_fault(f_fault),
      .d_illegal(d_illegal), .e_ovf(e_ovf), .m_daf(m_daf), .m_eret(m_eret),
      .irq_req(irq_req), .commit_ok(commit_ok), .redirect(redirect),
      .redirect_pc(redirect_pc), .kill(kill), .exc_cause(exc_cause),
      .exc_epc(exc_epc), .irq_en(irq_en)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // bench record of instructions in D(1), E(2), M(3)
   logic        sv  [1:3];
   logic [31:0] spc [1:3];
   logic        sff [1:3], sil [1:3], sov [1:3], sda [1:3], ser [1:3];
   logic [3:0]  e_cause;
   logic [31:0] e_epc;
   logic        e_ie;
   logic [SYNC-1:0] ih;

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] first_code(input logic ff, il, ov, da);
      if (ff)      return 4'h1;   // R3 earliest stage first
      else if (il) return 4'h2;
      else if (ov) return 4'h3;
      else if (da) return 4'h4;
      return 4'h0;
   endfunction

   // one cycle: called just after a rising edge
   task automatic step(input logic nv, input logic [31:0] npc, input logic ff, il, ov, da, er, irq);
      logic mv, flt, itake, taken, eret_go, redir, multi;
      logic [3:0] code;
      string ctag;
      f_valid = nv; f_pc = npc; f_fault = ff;
      d_illegal = sil[1]; e_ovf = sov[2]; m_daf = sda[3]; m_eret = ser[3];
      irq_req = irq;
      mv      = sv[3];
      flt     = mv & (sff[3] | sil[3] | sov[3] | sda[3]);
      code    = first_code(sff[3], sil[3], sov[3], sda[3]);
      multi   = (32'(sff[3]) + 32'(sil[3]) + 32'(sov[3]) + 32'(sda[3])) > 1;
      itake   = ih[SYNC-1] & e_ie & mv;
      taken   = itake | flt;
      eret_go = mv & ser[3] & ~taken;
      redir   = taken | eret_go;
      @(negedge clk);
      check("R7", "redirect", 32'(redirect), 32'(redir));
      check("R7", "kill", 32'(kill), redir ? 32'hF : 32'h0);
      check("R8", "commit_ok", 32'(commit_ok), 32'(mv & ~taken));
      if (taken)        check("R7", "redirect_pc", redirect_pc, HPC);
      else if (eret_go) check("R10", "redirect_pc", redirect_pc, e_epc);
      @(posedge clk); #1;
      if (taken) begin
         e_cause = itake ? 4'hA : code;
         e_epc   = spc[3];
         e_ie    = 1'b0;
      end else if (eret_go) e_ie = 1'b1;
      ctag = itake ? "R5" : (multi ? "R3" : "R4");
      check(ctag, "exc_cause", 32'(exc_cause), 32'(e_cause));
      check("R6", "exc_epc", exc_epc, e_epc);
      check(eret_go ? "R10" : "R9", "irq_en", 32'(irq_en), 32'(e_ie));
      ih = {ih[SYNC-2:0], irq};
      for (int k = 3; k > 1; k--) begin
         sv[k] = sv[k-1]; spc[k] = spc[k-1]; sff[k] = sff[k-1]; sil[k] = sil[k-1];
         sov[k] = sov[k-1]; sda[k] = sda[k-1]; ser[k] = ser[k-1];
      end
      sv[1] = nv; spc[1] = npc; sff[1] = ff; sil[1] = il; sov[1] = ov; sda[1] = da; ser[1] = er;
      if (redir) for (int k = 1; k <= 3; k++) sv[k] = 1'b0;   // R8 killed entries keep their flags
   endtask

   task automatic bubbles(input int n, input logic irq);
      for (int i = 0; i < n; i++) step(0, 32'h0, 0, 0, 0, 0, 0, irq);
   endtask

   initial begin
      logic lvl;
      void'($urandom(32'd20250611));
      for (int k = 1; k <= 3; k++) begin
         sv[k] = 0; spc[k] = 0; sff[k] = 0; sil[k] = 0; sov[k] = 0; sda[k] = 0; ser[k] = 0;
      end
      e_cause = 4'h0; e_epc = 32'h0; e_ie = 1'b1; ih = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check("R1", "exc_cause", 32'(exc_cause), 32'h0);
      check("R1", "exc_epc", exc_epc, 32'h0);
      check("R1", "irq_en", 32'(irq_en), 32'h1);
      check("R1", "redirect", 32'(redirect), 32'h0);
      check("R1", "commit_ok", 32'(commit_ok), 32'h0);

      // R2 clean instruction commits at M
      step(1, 32'h1000, 0, 0, 0, 0, 0, 0);
      bubbles(4, 0);
      // R3 fetch fault beats overflow; illegal beats data fault
      step(1, 32'h1004, 1, 0, 1, 0, 0, 0);  bubbles(4, 0);
      step(1, 32'h1008, 0, 1, 0, 1, 0, 0);  bubbles(4, 0);
      step(1, 32'h100C, 0, 0, 1, 1, 0, 0);  bubbles(4, 0);
      // R10 return restores PC and enable
      step(1, 32'h0180, 0, 0, 0, 0, 1, 0);  bubbles(4, 0);
      // R4 data fault alone; R8 younger faulting instr behind it is killed
      step(1, 32'h2000, 0, 0, 0, 1, 0, 0);
      step(1, 32'h2004, 1, 1, 1, 1, 0, 0);
      step(1, 32'h2008, 0, 0, 1, 0, 0, 0);
      bubbles(5, 0);
      step(1, 32'h0184, 0, 0, 0, 0, 1, 0);  bubbles(4, 0);
      // R5 interrupt overrides overflow in the same cycle
      bubbles(3, 1);
      step(1, 32'h3000, 0, 0, 1, 0, 0, 1);  bubbles(4, 1);
      // R9 interrupt ignored while disabled
      step(1, 32'h3004, 0, 0, 0, 0, 0, 1);
      step(1, 32'h3008, 0, 0, 0, 0, 0, 1);
      bubbles(4, 1);
      // R10 eret re-enables, pending interrupt then taken by next instr
      step(1, 32'h0188, 0, 0, 0, 0, 1, 1);
      bubbles(3, 1);
      step(1, 32'h300C, 0, 0, 0, 0, 0, 1);
      bubbles(4, 0);

      // constrained random
      lvl = 0;
      for (int c = 0; c < 4000; c++) begin
         logic nv, ff, il, ov, da, er;
         nv = ($urandom % 10) < 8;
         ff = ($urandom % 40) == 0;
         il = ($urandom % 40) == 0;
         ov = ($urandom % 40) == 0;
         da = ($urandom % 40) == 0;
         er = ($urandom % 20) == 0;
         if (($urandom % 30) == 0) lvl = ~lvl;
         step(nv, {$urandom} & 32'hFFFF_FFFC, ff, il, ov, da, er, lvl);
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule